// File: doc/BRIEF.md
# Variable-Length Instruction Field Parser

The parser takes an instruction stream one byte per clock and cuts each instruction into its fields. These are the size and repeat prefixes, an extension prefix that exists only in 64-bit mode, a primary opcode of one to three bytes, an optional addressing byte, an optional scale-index byte, an optional displacement and an optional immediate. When the last byte of an instruction has been taken, every field is presented at once, each with its own valid flag, and a one-cycle completion strobe fires. The fields then hold until the next instruction completes.

Each opcode can take an addressing byte and can carry an immediate of a given size. These two attributes come from a small attribute table that is written through a dedicated write port. The table is indexed by opcode map and opcode byte. The parser never stalls, so it accepts a byte in every cycle in which the input is valid.

Two cases depend on the mode input. In 64-bit mode, bytes 40h to 4Fh are taken as the extension prefix. In legacy mode the same bytes are complete one-byte instructions. An instruction that would grow past fifteen bytes is abandoned with an abort strobe, and the next byte starts a new instruction.

Top module: `insn_field_parser`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `done_o` and `abort_o` are low. `in_ready_o` is high in every cycle.
- R2: Bytes 66h, 67h, F2h and F3h seen before the opcode set `pfx_o` bits 0, 1, 2 and 3 respectively.
- R3: In 64-bit mode (`mode64_i`=1), a byte 4Xh before the opcode is consumed as the extension prefix. It sets `ext_vld_o` and reports X on `ext_o`. If several such bytes arrive, the last one wins.
- R4: `low_byte_o` is high exactly when the completed instruction carried an extension prefix. In that case byte-register codes 100 to 111 name low bytes.
- R5: In legacy mode (`mode64_i`=0), bytes 40h to 4Fh are opcodes in map 0.
- R6: A legacy prefix that arrives after an extension prefix in the same instruction sets `seq_err_o` for that instruction.
- R7: `map_o` is 1 after 0Fh, 2 after 0Fh 38h, 3 after 0Fh 3Ah, and 0 otherwise. `opc_o` is the final opcode byte.
- R8: A write with `tbl_we_i` stores {`tbl_modrm_i`, `tbl_imm_i`} for (`tbl_map_i`, `tbl_opc_i`). The write applies to opcode bytes taken after that clock edge. After reset, every entry means no addressing byte and no immediate.
- R9: The addressing byte has mod in bits 7:6 and r/m in bits 2:0. A scale-index byte follows it exactly when mod≠11 and r/m=100.
- R10: The displacement follows the addressing byte, or the scale-index byte when one is present. Its length is 1 byte for mod=01, 4 bytes for mod=10, 4 bytes for mod=00 with r/m=101, and 0 bytes otherwise. The bytes are assembled little-endian into `disp_o`, and `disp_len_o` gives the length in bytes.
- R11: Immediate code 0, 1, 2 or 3 gives 0, 1, 2 or 4 bytes. The immediate comes last and is assembled little-endian into `imm_o`, with its length on `imm_len_o`.
- R12: `done_o` pulses for one cycle, in the cycle after the last byte is taken. The fields and `len_o` (the byte count) are valid then and hold until the next `done_o`.
- R13: If the fifteenth byte is taken and the instruction is not yet complete, `abort_o` pulses instead of `done_o`. The field outputs keep their values, and the next byte starts a new instruction.
- R14: A cycle with `in_valid_i` low neither advances the parse nor raises a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode64_i | input | 1 | 1 selects 64-bit mode |
| in_valid_i | input | 1 | Input byte valid |
| in_byte_i | input | 8 | Instruction byte |
| in_ready_o | output | 1 | Byte accepted when valid (always high) |
| tbl_we_i | input | 1 | Attribute table write enable |
| tbl_map_i | input | 2 | Opcode map of the entry being written |
| tbl_opc_i | input | 8 | Opcode of the entry being written |
| tbl_modrm_i | input | 1 | Entry takes an addressing byte |
| tbl_imm_i | input | 2 | Entry immediate code |
| done_o | output | 1 | Instruction complete strobe |
| abort_o | output | 1 | Over-length abort strobe |
| pfx_o | output | 4 | Legacy prefixes seen {F3,F2,67,66} |
| ext_vld_o | output | 1 | Extension prefix present |
| ext_o | output | 4 | Extension prefix low nibble |
| low_byte_o | output | 1 | Byte codes 100 to 111 select low bytes |
| seq_err_o | output | 1 | Legacy prefix after extension prefix |
| map_o | output | 2 | Opcode map |
| opc_o | output | 8 | Opcode byte |
| modrm_vld_o | output | 1 | Addressing byte present |
| modrm_o | output | 8 | Addressing byte |
| sib_vld_o | output | 1 | Scale-index byte present |
| sib_o | output | 8 | Scale-index byte |
| disp_vld_o | output | 1 | Displacement present |
| disp_len_o | output | 3 | Displacement length in bytes |
| disp_o | output | 32 | Displacement value |
| imm_vld_o | output | 1 | Immediate present |
| imm_len_o | output | 3 | Immediate length in bytes |
| imm_o | output | 32 | Immediate value |
| len_o | output | 4 | Instruction length in bytes |

## Verification
The hardest situation to reach is the length limit. The fifteenth byte has to land in the middle of a field, and that needs a long prefix run followed by an opcode with a wide immediate. The stimulus builds that instruction and also the one that ends exactly on byte fifteen, then sends a short instruction to prove the parser resynchronises. The prefix-order error needs mode 64 together with an extension byte that comes before a legacy prefix. Idle gaps are inserted inside instructions to show that the parse state holds across cycles with no valid byte.

// File: rtl/ifp_pkg.sv
package ifp_pkg;
  localparam int unsigned MAX_LEN  = 15;
  localparam int unsigned LEN_W    = $clog2(MAX_LEN + 1);
  localparam int unsigned MAP_W    = 2;
  localparam int unsigned OPC_W    = 8;
  localparam int unsigned ATTR_W   = 3;
  localparam int unsigned FLD_W    = 32;
  localparam int unsigned FCNT_W   = $clog2(FLD_W / 8);
  localparam int unsigned FLEN_W   = FCNT_W + 1;

  localparam logic [7:0] B_OPSZ  = 8'h66;
  localparam logic [7:0] B_ADSZ  = 8'h67;
  localparam logic [7:0] B_REPNE = 8'hF2;
  localparam logic [7:0] B_REP   = 8'hF3;
  localparam logic [7:0] B_ESC   = 8'h0F;
  localparam logic [7:0] B_ESC38 = 8'h38;
  localparam logic [7:0] B_ESC3A = 8'h3A;
  localparam logic [3:0] EXT_HI  = 4'h4;

  typedef enum logic [2:0] {
    ST_PFX, ST_ESC1, ST_ESC2, ST_MODRM, ST_SIB, ST_DISP, ST_IMM
  } st_e;

  typedef struct packed {
    logic [3:0]        pfx;
    logic              ext_vld;
    logic [3:0]        ext;
    logic              seq_err;
    logic [MAP_W-1:0]  map;
    logic [OPC_W-1:0]  opc;
    logic              modrm_vld;
    logic [7:0]        modrm;
    logic              sib_vld;
    logic [7:0]        sib;
    logic [FLEN_W-1:0] disp_len;
    logic [FLD_W-1:0]  disp;
    logic [FLEN_W-1:0] imm_len;
    logic [FLD_W-1:0]  imm;
    logic [LEN_W-1:0]  len;
  } fld_t;

  function automatic logic [FLEN_W-1:0] imm_bytes(input logic [1:0] code);
    unique case (code)
      2'd0: imm_bytes = FLEN_W'(0);
      2'd1: imm_bytes = FLEN_W'(1);
      2'd2: imm_bytes = FLEN_W'(2);
      default: imm_bytes = FLEN_W'(4);
    endcase
  endfunction
endpackage

// File: rtl/ifp_attr_tbl.sv
module ifp_attr_tbl #(
  parameter int unsigned MAP_W  = 2,
  parameter int unsigned OPC_W  = 8,
  parameter int unsigned ATTR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [MAP_W-1:0]  wmap_i,
  input  logic [OPC_W-1:0]  wopc_i,
  input  logic [ATTR_W-1:0] wdata_i,
  input  logic [MAP_W-1:0]  rmap_i,
  input  logic [OPC_W-1:0]  ropc_i,
  output logic [ATTR_W-1:0] rdata_o
);
  localparam int unsigned IDX_W = MAP_W + OPC_W;
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [ATTR_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[{wmap_i, wopc_i}] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[{rmap_i, ropc_i}];
endmodule

// File: rtl/ifp_modrm_dec.sv
module ifp_modrm_dec #(
  parameter int unsigned FLEN_W = 3
) (
  input  logic [7:0]        modrm_i,
  output logic              sib_o,
  output logic [FLEN_W-1:0] dlen_o
);
  logic [1:0] mod_w;
  logic [2:0] rm_w;

  assign mod_w = modrm_i[7:6];
  assign rm_w  = modrm_i[2:0];
  assign sib_o = (mod_w != 2'b11) && (rm_w == 3'b100);

  always_comb begin
    unique case (mod_w)
      2'b01:   dlen_o = FLEN_W'(1);
      2'b10:   dlen_o = FLEN_W'(4);
      2'b00:   dlen_o = (rm_w == 3'b101) ? FLEN_W'(4) : FLEN_W'(0);
      default: dlen_o = FLEN_W'(0);
    endcase
  end
endmodule

// File: rtl/insn_field_parser.sv
module insn_field_parser
  import ifp_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        mode64_i,
  input  logic        in_valid_i,
  input  logic [7:0]  in_byte_i,
  output logic        in_ready_o,
  input  logic        tbl_we_i,
  input  logic [1:0]  tbl_map_i,
  input  logic [7:0]  tbl_opc_i,
  input  logic        tbl_modrm_i,
  input  logic [1:0]  tbl_imm_i,
  output logic        done_o,
  output logic        abort_o,
  output logic [3:0]  pfx_o,
  output logic        ext_vld_o,
  output logic [3:0]  ext_o,
  output logic        low_byte_o,
  output logic        seq_err_o,
  output logic [1:0]  map_o,
  output logic [7:0]  opc_o,
  output logic        modrm_vld_o,
  output logic [7:0]  modrm_o,
  output logic        sib_vld_o,
  output logic [7:0]  sib_o,
  output logic        disp_vld_o,
  output logic [2:0]  disp_len_o,
  output logic [31:0] disp_o,
  output logic        imm_vld_o,
  output logic [2:0]  imm_len_o,
  output logic [31:0] imm_o,
  output logic [3:0]  len_o
);
  st_e               st_q, st_d;
  fld_t              work_q, out_q, w;
  logic [FCNT_W-1:0] fcnt_q, fcnt_d;
  logic              done_q, abort_q;
  logic              last, abort, take_opc, pfx_hit;
  logic [1:0]        pfx_idx;
  logic [MAP_W-1:0]  opc_map;
  logic [ATTR_W-1:0] attr;
  logic [FLEN_W-1:0] imm_n, dlen;
  logic              need_sib;
  logic [7:0]        b;

  assign b          = in_byte_i;
  assign in_ready_o = 1'b1;

  always_comb begin
    unique case (st_q)
      ST_ESC1: opc_map = MAP_W'(1);
      ST_ESC2: opc_map = work_q.map;
      default: opc_map = '0;
    endcase
  end

  ifp_attr_tbl #(.MAP_W(MAP_W), .OPC_W(OPC_W), .ATTR_W(ATTR_W)) u_tbl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (tbl_we_i),
    .wmap_i  (tbl_map_i),
    .wopc_i  (tbl_opc_i),
    .wdata_i ({tbl_modrm_i, tbl_imm_i}),
    .rmap_i  (opc_map),
    .ropc_i  (b),
    .rdata_o (attr)
  );

  ifp_modrm_dec #(.FLEN_W(FLEN_W)) u_modrm (
    .modrm_i (b),
    .sib_o   (need_sib),
    .dlen_o  (dlen)
  );

  assign imm_n = imm_bytes(attr[1:0]);

  always_comb begin
    pfx_hit = 1'b1;
    pfx_idx = 2'd0;
    unique case (b)
      B_OPSZ:  pfx_idx = 2'd0;
      B_ADSZ:  pfx_idx = 2'd1;
      B_REPNE: pfx_idx = 2'd2;
      B_REP:   pfx_idx = 2'd3;
      default: pfx_hit = 1'b0;
    endcase
  end

  always_comb begin
    w        = work_q;
    w.len    = work_q.len + LEN_W'(1);
    st_d     = st_q;
    fcnt_d   = fcnt_q;
    last     = 1'b0;
    take_opc = 1'b0;
    unique case (st_q)
      ST_PFX: begin
        if (pfx_hit) begin
          w.pfx[pfx_idx] = 1'b1;
          if (work_q.ext_vld) w.seq_err = 1'b1;
        end else if (mode64_i && b[7:4] == EXT_HI) begin
          w.ext_vld = 1'b1;
          w.ext     = b[3:0];
        end else if (b == B_ESC) begin
          st_d = ST_ESC1;
        end else begin
          take_opc = 1'b1;
        end
      end
      ST_ESC1: begin
        if (b == B_ESC38) begin
          w.map = MAP_W'(2);
          st_d  = ST_ESC2;
        end else if (b == B_ESC3A) begin
          w.map = MAP_W'(3);
          st_d  = ST_ESC2;
        end else begin
          take_opc = 1'b1;
        end
      end
      ST_ESC2: take_opc = 1'b1;
      ST_MODRM: begin
        w.modrm_vld = 1'b1;
        w.modrm     = b;
        w.disp_len  = dlen;
        if (need_sib)                 st_d = ST_SIB;
        else if (dlen != '0)          st_d = ST_DISP;
        else if (work_q.imm_len != '0) st_d = ST_IMM;
        else                          last = 1'b1;
      end
      ST_SIB: begin
        w.sib_vld = 1'b1;
        w.sib     = b;
        if (work_q.disp_len != '0)     st_d = ST_DISP;
        else if (work_q.imm_len != '0) st_d = ST_IMM;
        else                           last = 1'b1;
      end
      ST_DISP: begin
        w.disp[{fcnt_q, 3'b000} +: 8] = b;
        if ({1'b0, fcnt_q} == work_q.disp_len - FLEN_W'(1)) begin
          fcnt_d = '0;
          if (work_q.imm_len != '0) st_d = ST_IMM;
          else                      last = 1'b1;
        end else begin
          fcnt_d = fcnt_q + FCNT_W'(1);
        end
      end
      ST_IMM: begin
        w.imm[{fcnt_q, 3'b000} +: 8] = b;
        if ({1'b0, fcnt_q} == work_q.imm_len - FLEN_W'(1)) begin
          fcnt_d = '0;
          last   = 1'b1;
        end else begin
          fcnt_d = fcnt_q + FCNT_W'(1);
        end
      end
      default: st_d = ST_PFX;
    endcase
    if (take_opc) begin
      w.map     = opc_map;
      w.opc     = b;
      w.imm_len = imm_n;
      if (attr[2])            st_d = ST_MODRM;
      else if (imm_n != '0)   st_d = ST_IMM;
      else                    last = 1'b1;
    end
  end

  assign abort = !last && (work_q.len == LEN_W'(MAX_LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_PFX;
      work_q  <= '0;
      out_q   <= '0;
      fcnt_q  <= '0;
      done_q  <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      abort_q <= 1'b0;
      if (in_valid_i) begin
        if (last || abort) begin
          st_q   <= ST_PFX;
          work_q <= '0;
          fcnt_q <= '0;
          if (last) begin
            out_q  <= w;
            done_q <= 1'b1;
          end else begin
            abort_q <= 1'b1;
          end
        end else begin
          st_q   <= st_d;
          work_q <= w;
          fcnt_q <= fcnt_d;
        end
      end
    end
  end

  assign done_o      = done_q;
  assign abort_o     = abort_q;
  assign pfx_o       = out_q.pfx;
  assign ext_vld_o   = out_q.ext_vld;
  assign ext_o       = out_q.ext;
  assign low_byte_o  = out_q.ext_vld;
  assign seq_err_o   = out_q.seq_err;
  assign map_o       = out_q.map;
  assign opc_o       = out_q.opc;
  assign modrm_vld_o = out_q.modrm_vld;
  assign modrm_o     = out_q.modrm;
  assign sib_vld_o   = out_q.sib_vld;
  assign sib_o       = out_q.sib;
  assign disp_vld_o  = out_q.disp_len != '0;
  assign disp_len_o  = out_q.disp_len;
  assign disp_o      = out_q.disp;
  assign imm_vld_o   = out_q.imm_len != '0;
  assign imm_len_o   = out_q.imm_len;
  assign imm_o       = out_q.imm;
  assign len_o       = out_q.len;
endmodule

// File: rtl/ifp_checker.sv
module ifp_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       in_valid_i,
  input logic       done_o,
  input logic       abort_o,
  input logic       modrm_vld_o,
  input logic [7:0] modrm_o,
  input logic       sib_vld_o,
  input logic [2:0] disp_len_o,
  input logic [3:0] len_o
);
  a_r12_strobes_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && abort_o));

  a_r12_done_needs_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(in_valid_i));

  a_r13_abort_needs_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> $past(in_valid_i));

  a_r12_len_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> len_o != 4'd0);

  a_r13_abort_holds_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> $stable(len_o));

  a_r9_sib_rule: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && sib_vld_o) |-> (modrm_vld_o && modrm_o[7:6] != 2'b11 && modrm_o[2:0] == 3'b100));

  a_r10_disp8_rule: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && modrm_vld_o && modrm_o[7:6] == 2'b01) |-> disp_len_o == 3'd1);
endmodule

bind insn_field_parser ifp_checker u_chk (.*);

// File: tb/insn_field_parser_bench.sv
module insn_field_parser_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mode64 = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = 8'h00;
  logic        in_ready;
  logic        tbl_we = 1'b0;
  logic [1:0]  tbl_map = 2'd0;
  logic [7:0]  tbl_opc = 8'h00;
  logic        tbl_modrm = 1'b0;
  logic [1:0]  tbl_imm = 2'd0;
  logic        done, abort_s, ext_vld, low_byte, seq_err;
  logic        modrm_vld, sib_vld, disp_vld, imm_vld;
  logic [3:0]  pfx, ext, len;
  logic [1:0]  map;
  logic [7:0]  opc, modrm, sib;
  logic [2:0]  disp_len, imm_len;
  logic [31:0] disp, imm;

  int nchk = 0;
  int nerr = 0;
  logic [2:0] tm [0:1023];
  logic [3:0] held_len = 4'd0;

  always #10 clk = ~clk;

  insn_field_parser u_insn_field_parser (
    .clk_i(clk), .rst_ni(rst_ni), .mode64_i(mode64), .in_valid_i(in_valid),
    .in_byte_i(in_byte), .in_ready_o(in_ready), .tbl_we_i(tbl_we),
    .tbl_map_i(tbl_map), .tbl_opc_i(tbl_opc), .tbl_modrm_i(tbl_modrm),
    .tbl_imm_i(tbl_imm), .done_o(done), .abort_o(abort_s), .pfx_o(pfx),
    .ext_vld_o(ext_vld), .ext_o(ext), .low_byte_o(low_byte), .seq_err_o(seq_err),
    .map_o(map), .opc_o(opc), .modrm_vld_o(modrm_vld), .modrm_o(modrm),
    .sib_vld_o(sib_vld), .sib_o(sib), .disp_vld_o(disp_vld), .disp_len_o(disp_len),
    .disp_o(disp), .imm_vld_o(imm_vld), .imm_len_o(imm_len), .imm_o(imm), .len_o(len)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_tbl(input int m, input int op, input bit has_m, input int code);
    tbl_we = 1'b1; tbl_map = 2'(m); tbl_opc = 8'(op); tbl_modrm = has_m; tbl_imm = 2'(code);
    tm[m*256 + op] = {has_m, 2'(code)};
    @(posedge clk); #1;
    tbl_we = 1'b0;
  endtask

  function automatic logic [7:0] getb(input logic [143:0] v, input int nb, input int k);
    if (k >= nb) return 8'h00;
    return v[8*(nb-1-k) +: 8];
  endfunction

  // Behavioural walk over the byte string, then drive and compare each clock.
  task automatic run(input bit m64, input int nb, input logic [143:0] v, input bit gap);
    int i = 0;
    int n;
    bit ab;
    logic [7:0] bt;
    logic [2:0] at;
    logic [3:0] ep = 0, ee = 0;
    bit ev = 0, es = 0, emv = 0, esv = 0;
    int emap = 0, edl = 0, eil = 0;
    logic [7:0] eop, em = 0, esb = 0;
    logic [31:0] ed = 0, ei = 0;
    while (1) begin
      bt = getb(v, nb, i);
      if (bt == 8'h66)      begin ep[0] = 1; es = es | ev; i++; end
      else if (bt == 8'h67) begin ep[1] = 1; es = es | ev; i++; end
      else if (bt == 8'hF2) begin ep[2] = 1; es = es | ev; i++; end
      else if (bt == 8'hF3) begin ep[3] = 1; es = es | ev; i++; end
      else if (m64 && bt[7:4] == 4'h4) begin ev = 1; ee = bt[3:0]; i++; end
      else break;
    end
    if (bt == 8'h0F) begin
      i++;
      bt = getb(v, nb, i);
      if (bt == 8'h38)      begin emap = 2; i++; end
      else if (bt == 8'h3A) begin emap = 3; i++; end
      else emap = 1;
    end
    eop = getb(v, nb, i); i++;
    at = tm[emap*256 + int'(eop)];
    eil = (at[1:0] == 2'd3) ? 4 : int'(at[1:0]);
    if (at[2]) begin
      em = getb(v, nb, i); emv = 1; i++;
      if (em[7:6] != 2'b11 && em[2:0] == 3'b100) begin esv = 1; esb = getb(v, nb, i); i++; end
      if (em[7:6] == 2'b01) edl = 1;
      else if (em[7:6] == 2'b10) edl = 4;
      else if (em[7:6] == 2'b00 && em[2:0] == 3'b101) edl = 4;
      for (int k = 0; k < edl; k++) begin ed = ed | (32'(getb(v, nb, i)) << (8*k)); i++; end
    end
    for (int k = 0; k < eil; k++) begin ei = ei | (32'(getb(v, nb, i)) << (8*k)); i++; end
    n = i;
    ab = (n > 15);
    if (ab) n = 15;

    mode64 = m64;
    for (int k = 0; k < n; k++) begin
      in_valid = 1'b1;
      in_byte  = getb(v, nb, k);
      @(posedge clk); #1;
      in_valid = 1'b0;
      chk("R12 done strobe", 32'(done), 32'((k == n-1) && !ab));
      chk("R13 abort strobe", 32'(abort_s), 32'((k == n-1) && ab));
      if (gap && k < n-1) begin
        @(posedge clk); #1;
        chk("R14 idle no done", 32'(done), 0);
        chk("R14 idle no abort", 32'(abort_s), 0);
      end
    end
    if (ab) begin
      chk("R13 fields held after abort", 32'(len), 32'(held_len));
    end else begin
      chk("R2 prefixes", 32'(pfx), 32'(ep));
      chk("R3 ext valid", 32'(ext_vld), 32'(ev));
      chk("R3 ext nibble", 32'(ext), 32'(ee));
      chk("R4 low byte flag", 32'(low_byte), 32'(ev));
      chk("R6 sequence error", 32'(seq_err), 32'(es));
      chk("R7 map", 32'(map), 32'(emap));
      chk("R7 opcode", 32'(opc), 32'(eop));
      chk("R8 modrm valid", 32'(modrm_vld), 32'(emv));
      chk("R9 modrm byte", 32'(modrm), 32'(em));
      chk("R9 sib valid", 32'(sib_vld), 32'(esv));
      chk("R9 sib byte", 32'(sib), 32'(esb));
      chk("R10 disp valid", 32'(disp_vld), 32'(edl != 0));
      chk("R10 disp len", 32'(disp_len), 32'(edl));
      chk("R10 disp value", disp, ed);
      chk("R11 imm valid", 32'(imm_vld), 32'(eil != 0));
      chk("R11 imm len", 32'(imm_len), 32'(eil));
      chk("R11 imm value", imm, ei);
      chk("R12 length", 32'(len), 32'(n));
      held_len = 4'(n);
    end
    @(posedge clk); #1;
    chk("R12 single pulse", 32'(done), 0);
  endtask

  initial begin
    #(20 * 200000);
    nerr++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) tm[i] = 3'b000;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset done", 32'(done), 0);
    chk("R1 reset abort", 32'(abort_s), 0);
    rst_ni = 1'b1;
    @(posedge clk); #1;
    chk("R1 post-reset done", 32'(done), 0);
    chk("R1 ready", 32'(in_ready), 1);

    // R8: empty table after reset makes 01h a one-byte instruction
    run(0, 1, 144'h01, 0);
    run(0, 1, 144'hD8, 0);

    wr_tbl(0, 8'h01, 1, 0);
    wr_tbl(0, 8'h05, 0, 3);
    wr_tbl(0, 8'h6A, 0, 1);
    wr_tbl(0, 8'hC2, 0, 2);
    wr_tbl(0, 8'hC7, 1, 3);
    wr_tbl(0, 8'h8B, 1, 0);
    wr_tbl(1, 8'hAF, 1, 0);
    wr_tbl(2, 8'h00, 1, 0);
    wr_tbl(3, 8'h0F, 1, 1);

    run(0, 1, 144'h90, 0);
    run(0, 2, 144'h01D8, 0);
    run(0, 4, 144'h8B442408, 1);              // R9 sib + R10 disp8, with gaps (R14)
    run(0, 6, 144'h8B0511223344, 0);          // R10 mod00 rm101 disp32
    run(0, 10, 144'hC78011223344AABBCCDD, 1); // R10 disp32 then R11 imm32
    run(0, 5, 144'h66F30FAFC1, 0);            // R2, R7 map1
    run(0, 4, 144'h0F3800C1, 0);              // R7 map2
    run(0, 5, 144'h0F3A0FC108, 0);            // R7 map3, R11 imm8
    run(0, 3, 144'hC23412, 0);                // R11 imm16
    run(0, 2, 144'h6A7F, 0);
    run(0, 1, 144'h41, 0);                    // R5 legacy: 41h is an opcode
    run(1, 4, 144'h488B0425, 0);              // R3 ext, sib without disp
    run(1, 7, 144'h6641_0511223344, 0);       // R3, R4
    run(1, 4, 144'h48426690, 0);              // R6 legacy after ext, last ext wins
    run(0, 18, {{13{8'h66}}, 8'h05, 32'h11223344}, 0); // R13 abort
    run(0, 1, 144'h90, 0);                    // R13 resync
    run(0, 15, {24'h0, {10{8'h66}}, 8'h05, 32'hCAFEF00D}, 0); // exactly 15 bytes
    wr_tbl(0, 8'h90, 0, 1);                   // R8 rewrite
    run(0, 2, 144'h9011, 0);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule